// File: doc/BRIEF.md
# Adaptive Security Primitive Controller

This block is the control state machine for one reconfigurable cryptographic accelerator. A host processor writes a word of algorithm parameters. The controller checks that word and then starts a configuration of the accelerator. It waits for the accelerator to report ready and then enables it to run. When the accelerator reports termination, the controller either parks it, still loaded, or releases it. The host can restart the sequence from a parked or released accelerator, or write new parameters at any of those points.

While the accelerator runs, the controller re-evaluates its datapath configuration every cycle. There are eight configurations. Each one pairs a pipeline depth of 1, 2, 4 or 8 with either one or two key generators. A host-written table holds the sustainable throughput of each configuration. The controller compares the throughput the host asks for against this table and moves one configuration step up or down. A low battery or a poor channel pushes the controller toward cheaper configurations. A request from the system security controller overrides all of this and forces a new configuration cycle from any state.

Top module: `sec_prim_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (INIT) and `cfg_id` is 0. `cfg_start`, `run_en` and `prm_err` are all 0. The state codes are INIT=0, CHECK=1, CONFIG=2, RUN=3, IDLE=4, STOP=5.
- R2: A `prm_wr` in INIT moves the controller to CHECK on the next edge. On the edge after that, the check completes. If the key-size field (`prm_data[1:0]`) is 3, the word is rejected: the controller returns to INIT and sets `prm_err`. Otherwise the word is copied to `alg_prm`, `prm_err` clears and the controller enters CONFIG.
- R3: `cfg_start` is high only in the first cycle after entry to CONFIG. `run_en` is high exactly while the state is RUN.
- R4: In CONFIG, with `sec_req` low, `prim_ready` moves the controller to RUN.
- R5: In RUN, `prim_done` moves the controller to IDLE if `keep_loaded` is 1, and to STOP otherwise.
- R6: In IDLE or STOP, `restart` returns the controller to INIT.
- R7: A `prm_wr` in RUN, IDLE or STOP starts a new check (CHECK). A word that passes the check leads to CONFIG.
- R8: `sec_req` high in any state other than CONFIG forces CONFIG on the next edge and pulses `cfg_start`. While `sec_req` stays high, the controller stays in CONFIG and ignores `prim_ready`. A security request leaves `cfg_id` unchanged.
- R9: In RUN, if the required throughput is greater than the table entry for the current `cfg_id`, and `cfg_id` is below 7, `cfg_id` goes up by one and the controller enters CONFIG.
- R10: In RUN, if `cfg_id` is above 0 and the required throughput is no greater than the entry for `cfg_id`−1, `cfg_id` goes down by one and the controller enters CONFIG. If neither R9 nor R10 applies, the controller stays in RUN.
- R11: In RUN, a power or channel trigger steps `cfg_id` down by one and the controller enters CONFIG. The trigger is `batt_low` high, or `chan_q` below `chan_thr`. If `cfg_id` is already 0, the controller stays in RUN.
- R12: Triggers in the same cycle are resolved in a fixed priority order. From highest to lowest:
  - `sec_req`
  - `prm_wr`
  - `prim_done`
  - the power or channel trigger
  - throughput adaptation

  While a power or channel trigger is active, no upward step is taken.
- R13: Configuration identifier = key-generator index × 4 + log2(pipeline depth). After reset, entry i of the table is 8 × depth × key generators. A `tbl_wr` replaces entry `tbl_idx` with `tbl_data` on the next edge, and later evaluations use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prm_wr | input | 1 | Host parameter write strobe |
| prm_data | input | 8 | Algorithm parameter word; bits [1:0] are the key-size field |
| tbl_wr | input | 1 | Throughput table write strobe |
| tbl_idx | input | 3 | Table entry to write |
| tbl_data | input | 8 | Sustainable throughput for that entry |
| req_tput | input | 8 | Throughput required by the application |
| batt_low | input | 1 | Battery low flag |
| chan_q | input | 4 | Communication channel quality |
| chan_thr | input | 4 | Channel quality threshold |
| prim_ready | input | 1 | Accelerator configured and ready |
| prim_done | input | 1 | Accelerator computation terminated |
| keep_loaded | input | 1 | On termination: 1 = park the accelerator (IDLE), 0 = release it (STOP) |
| restart | input | 1 | Restart request from IDLE or STOP |
| sec_req | input | 1 | Reconfiguration demand from the security controller |
| cfg_id | output | 3 | Selected datapath configuration |
| cfg_start | output | 1 | One-cycle configuration start pulse |
| run_en | output | 1 | Accelerator run enable |
| state_o | output | 3 | Current state code |
| prm_err | output | 1 | Last parameter word was rejected |
| alg_prm | output | 8 | Last accepted parameter word |

## Verification
Every result is held in a register that loads on the edge after its stimulus. A transition, `cfg_start` and a `cfg_id` step therefore all appear one edge after the triggering input is applied. A parameter word takes two edges to reach CONFIG, one into CHECK and one out of it. A table write acts one edge later than that, because the new entry is first compared on the edge after the write. The bench changes its inputs two nanoseconds after a rising edge and reads the outputs just before it drives the next inputs. Each check therefore sees exactly the edges counted above.

// File: rtl/spc_pkg.sv
package spc_pkg;
   typedef enum logic [2:0] {
      ST_INIT   = 3'd0,
      ST_CHECK  = 3'd1,
      ST_CONFIG = 3'd2,
      ST_RUN    = 3'd3,
      ST_IDLE   = 3'd4,
      ST_STOP   = 3'd5
   } spc_state_e;
endpackage

// File: rtl/spc_cap_table.sv
module spc_cap_table #(
   parameter int DEPTHS = 4,
   parameter int KGS    = 2,
   parameter int TP_W   = 8,
   parameter int BASE   = 8,
   localparam int NCFG  = DEPTHS * KGS,
   localparam int ID_W  = $clog2(NCFG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [ID_W-1:0] wr_idx,
   input  logic [TP_W-1:0] wr_data,
   input  logic [ID_W-1:0] rd_idx,
   output logic [TP_W-1:0] cap_cur,
   output logic [TP_W-1:0] cap_lo
);
   logic [TP_W-1:0] cap_q [NCFG];

   for (genvar g = 0; g < NCFG; g++) begin : g_ent
      localparam int RST_VAL = BASE * (1 << (g % DEPTHS)) * (g / DEPTHS + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cap_q[g] <= TP_W'(RST_VAL);
         else if (wr && wr_idx == ID_W'(g))
            cap_q[g] <= wr_data;
      end
   end

   logic [ID_W-1:0] lo_idx;
   assign lo_idx  = rd_idx - 1'b1;
   assign cap_cur = cap_q[rd_idx];
   assign cap_lo  = cap_q[lo_idx];
endmodule

// File: rtl/spc_adapt.sv
module spc_adapt #(
   parameter int NCFG = 8,
   parameter int TP_W = 8,
   parameter int CQ_W = 4,
   localparam int ID_W = $clog2(NCFG)
) (
   input  logic [ID_W-1:0] cfg_id,
   input  logic [TP_W-1:0] cap_cur,
   input  logic [TP_W-1:0] cap_lo,
   input  logic [TP_W-1:0] req_tput,
   input  logic            batt_low,
   input  logic [CQ_W-1:0] chan_q,
   input  logic [CQ_W-1:0] chan_thr,
   output logic            step_up,
   output logic            step_dn
);
   localparam logic [ID_W-1:0] TOP_ID = ID_W'(NCFG - 1);

   logic pwr_trig;
   logic at_bottom;
   logic at_top;

   assign pwr_trig  = batt_low | (chan_q < chan_thr);
   assign at_bottom = (cfg_id == '0);
   assign at_top    = (cfg_id == TOP_ID);

   always_comb begin
      step_up = 1'b0;
      step_dn = 1'b0;
      if (pwr_trig)
         step_dn = !at_bottom;
      else if (req_tput > cap_cur && !at_top)
         step_up = 1'b1;
      else if (!at_bottom && req_tput <= cap_lo)
         step_dn = 1'b1;
   end
endmodule

// File: rtl/spc_fsm.sv
module spc_fsm
   import spc_pkg::*;
#(
   parameter int PRM_W    = 8,
   parameter int KEY_W    = 2,
   parameter int ID_W     = 3,
   parameter int INIT_CFG = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prm_wr,
   input  logic [PRM_W-1:0] prm_data,
   input  logic             prim_ready,
   input  logic             prim_done,
   input  logic             keep_loaded,
   input  logic             restart,
   input  logic             sec_req,
   input  logic             step_up,
   input  logic             step_dn,
   output spc_state_e       state_q,
   output logic [ID_W-1:0]  cfg_q,
   output logic             start_q,
   output logic             err_q,
   output logic [PRM_W-1:0] alg_q
);
   spc_state_e       nxt;
   logic [ID_W-1:0]  cfg_n;
   logic             err_n;
   logic [PRM_W-1:0] alg_n;
   logic [PRM_W-1:0] pend_q, pend_n;
   logic             key_bad;

   assign key_bad = &pend_q[KEY_W-1:0];

   always_comb begin
      nxt    = state_q;
      cfg_n  = cfg_q;
      err_n  = err_q;
      alg_n  = alg_q;
      pend_n = pend_q;
      if (sec_req) begin
         nxt = ST_CONFIG;
      end else begin
         unique case (state_q)
            ST_INIT: if (prm_wr) begin
               nxt    = ST_CHECK;
               pend_n = prm_data;
            end
            ST_CHECK: if (key_bad) begin
               nxt   = ST_INIT;
               err_n = 1'b1;
            end else begin
               nxt   = ST_CONFIG;
               err_n = 1'b0;
               alg_n = pend_q;
            end
            ST_CONFIG: if (prim_ready) nxt = ST_RUN;
            ST_RUN: if (prm_wr) begin
               nxt    = ST_CHECK;
               pend_n = prm_data;
            end else if (prim_done) begin
               nxt = keep_loaded ? ST_IDLE : ST_STOP;
            end else if (step_up) begin
               nxt   = ST_CONFIG;
               cfg_n = cfg_q + 1'b1;
            end else if (step_dn) begin
               nxt   = ST_CONFIG;
               cfg_n = cfg_q - 1'b1;
            end
            ST_IDLE, ST_STOP: if (prm_wr) begin
               nxt    = ST_CHECK;
               pend_n = prm_data;
            end else if (restart) begin
               nxt = ST_INIT;
            end
            default: nxt = ST_INIT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_INIT;
         cfg_q   <= ID_W'(INIT_CFG);
         start_q <= 1'b0;
         err_q   <= 1'b0;
         alg_q   <= '0;
         pend_q  <= '0;
      end else begin
         state_q <= nxt;
         cfg_q   <= cfg_n;
         start_q <= (nxt == ST_CONFIG) && (state_q != ST_CONFIG);
         err_q   <= err_n;
         alg_q   <= alg_n;
         pend_q  <= pend_n;
      end
   end
endmodule

// File: rtl/sec_prim_ctrl.sv
module sec_prim_ctrl
   import spc_pkg::*;
#(
   parameter int DEPTHS   = 4,
   parameter int KGS      = 2,
   parameter int TP_W     = 8,
   parameter int BASE     = 8,
   parameter int CQ_W     = 4,
   parameter int PRM_W    = 8,
   parameter int KEY_W    = 2,
   parameter int INIT_CFG = 0,
   localparam int NCFG    = DEPTHS * KGS,
   localparam int ID_W    = $clog2(NCFG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prm_wr,
   input  logic [PRM_W-1:0] prm_data,
   input  logic             tbl_wr,
   input  logic [ID_W-1:0]  tbl_idx,
   input  logic [TP_W-1:0]  tbl_data,
   input  logic [TP_W-1:0]  req_tput,
   input  logic             batt_low,
   input  logic [CQ_W-1:0]  chan_q,
   input  logic [CQ_W-1:0]  chan_thr,
   input  logic             prim_ready,
   input  logic             prim_done,
   input  logic             keep_loaded,
   input  logic             restart,
   input  logic             sec_req,
   output logic [ID_W-1:0]  cfg_id,
   output logic             cfg_start,
   output logic             run_en,
   output logic [2:0]       state_o,
   output logic             prm_err,
   output logic [PRM_W-1:0] alg_prm
);
   localparam longint MAX_CAP = longint'(BASE) * (64'd1 << (DEPTHS - 1)) * KGS;

   if (DEPTHS < 1 || KGS < 1 || NCFG < 2) begin : g_bad_shape
      $error("sec_prim_ctrl: need at least two configurations");
   end
   if ((DEPTHS & (DEPTHS - 1)) != 0) begin : g_bad_depths
      $error("sec_prim_ctrl: DEPTHS must be a power of two");
   end
   if (MAX_CAP >= (64'd1 << TP_W)) begin : g_bad_width
      $error("sec_prim_ctrl: TP_W too narrow for default capacities");
   end
   if (KEY_W < 1 || KEY_W > PRM_W) begin : g_bad_key
      $error("sec_prim_ctrl: key field must fit in the parameter word");
   end
   if (INIT_CFG < 0 || INIT_CFG >= NCFG) begin : g_bad_init
      $error("sec_prim_ctrl: INIT_CFG out of range");
   end

   spc_state_e      st;
   logic [TP_W-1:0] cap_cur, cap_lo;
   logic            step_up, step_dn;

   spc_cap_table #(
      .DEPTHS (DEPTHS),
      .KGS    (KGS),
      .TP_W   (TP_W),
      .BASE   (BASE)
   ) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (tbl_wr),
      .wr_idx  (tbl_idx),
      .wr_data (tbl_data),
      .rd_idx  (cfg_id),
      .cap_cur (cap_cur),
      .cap_lo  (cap_lo)
   );

   spc_adapt #(
      .NCFG (NCFG),
      .TP_W (TP_W),
      .CQ_W (CQ_W)
   ) u_adapt (
      .cfg_id   (cfg_id),
      .cap_cur  (cap_cur),
      .cap_lo   (cap_lo),
      .req_tput (req_tput),
      .batt_low (batt_low),
      .chan_q   (chan_q),
      .chan_thr (chan_thr),
      .step_up  (step_up),
      .step_dn  (step_dn)
   );

   spc_fsm #(
      .PRM_W    (PRM_W),
      .KEY_W    (KEY_W),
      .ID_W     (ID_W),
      .INIT_CFG (INIT_CFG)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .prm_wr      (prm_wr),
      .prm_data    (prm_data),
      .prim_ready  (prim_ready),
      .prim_done   (prim_done),
      .keep_loaded (keep_loaded),
      .restart     (restart),
      .sec_req     (sec_req),
      .step_up     (step_up),
      .step_dn     (step_dn),
      .state_q     (st),
      .cfg_q       (cfg_id),
      .start_q     (cfg_start),
      .err_q       (prm_err),
      .alg_q       (alg_prm)
   );

   assign state_o = st;
   assign run_en  = (st == ST_RUN);
endmodule

// File: rtl/spc_chk.sv
module spc_chk #(
   parameter int ID_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sec_req,
   input logic            prm_wr,
   input logic            prim_ready,
   input logic            prim_done,
   input logic [ID_W-1:0] cfg_id,
   input logic            cfg_start,
   input logic            run_en,
   input logic [2:0]      state_o
);
   // R3: the start pulse lasts one cycle
   a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_start |=> !cfg_start);

   // R3: the accelerator never runs while a configuration is starting
   a_r3_no_run_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |-> !cfg_start);

   // R8: a security request forces CONFIG with a start pulse
   a_r8_sec_forces: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_req && state_o != 3'd2) |=> (state_o == 3'd2 && cfg_start));

   // R8: the controller stays in CONFIG while the request is held
   a_r8_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_req && state_o == 3'd2) |=> (state_o == 3'd2));

   // R2: INIT is left only through CHECK, unless a security request forces CONFIG
   a_r2_init_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd0 && !sec_req) |=> (state_o == 3'd0 || state_o == 3'd1));

   // R4: ready in CONFIG leads to RUN
   a_r4_ready_run: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd2 && prim_ready && !sec_req) |=> (state_o == 3'd3));

   // R5: termination in RUN leads to IDLE or STOP
   a_r5_done_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd3 && prim_done && !sec_req && !prm_wr)
      |=> (state_o == 3'd4 || state_o == 3'd5));

   // R9 and R10: the configuration moves one step at a time, together with a start pulse
   a_r9_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_id) |-> (cfg_start &&
         (cfg_id == $past(cfg_id) + 1'b1 || cfg_id == $past(cfg_id) - 1'b1)));
endmodule

bind sec_prim_ctrl spc_chk #(.ID_W(ID_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sec_req    (sec_req),
   .prm_wr     (prm_wr),
   .prim_ready (prim_ready),
   .prim_done  (prim_done),
   .cfg_id     (cfg_id),
   .cfg_start  (cfg_start),
   .run_en     (run_en),
   .state_o    (state_o)
);

// File: tb/sec_prim_ctrl_tb.sv
`timescale 1ns/1ps
module sec_prim_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prm_wr = 1'b0;
   logic [7:0] prm_data = '0;
   logic       tbl_wr = 1'b0;
   logic [2:0] tbl_idx = '0;
   logic [7:0] tbl_data = '0;
   logic [7:0] req_tput = 8'd8;
   logic       batt_low = 1'b0;
   logic [3:0] chan_q = 4'd9;
   logic [3:0] chan_thr = 4'd5;
   logic       prim_ready = 1'b0;
   logic       prim_done = 1'b0;
   logic       keep_loaded = 1'b0;
   logic       restart = 1'b0;
   logic       sec_req = 1'b0;
   logic [2:0] cfg_id;
   logic       cfg_start;
   logic       run_en;
   logic [2:0] state_o;
   logic       prm_err;
   logic [7:0] alg_prm;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   sec_prim_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .prm_wr(prm_wr), .prm_data(prm_data),
      .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
      .req_tput(req_tput), .batt_low(batt_low), .chan_q(chan_q),
      .chan_thr(chan_thr), .prim_ready(prim_ready), .prim_done(prim_done),
      .keep_loaded(keep_loaded), .restart(restart), .sec_req(sec_req),
      .cfg_id(cfg_id), .cfg_start(cfg_start), .run_en(run_en),
      .state_o(state_o), .prm_err(prm_err), .alg_prm(alg_prm)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic give_ready(input int req);
      req_tput   = 8'(req);
      prim_ready = 1'b1;
      tick();
      prim_ready = 1'b0;
      chk("R4 ready to RUN", state_o, 3);
      chk("R3 run_en in RUN", run_en, 1);
   endtask

   task automatic send_prm(input int val);
      prm_data = 8'(val);
      prm_wr   = 1'b1;
      tick();
      prm_wr   = 1'b0;
      chk("R2/R7 CHECK entered", state_o, 1);
   endtask

   task automatic t_reset();
      chk("R1 state", state_o, 0);
      chk("R1 cfg_id", cfg_id, 0);
      chk("R1 cfg_start", cfg_start, 0);
      chk("R1 run_en", run_en, 0);
      chk("R1 prm_err", prm_err, 0);
   endtask

   task automatic t_params();
      send_prm(8'h03);
      tick();
      chk("R2 reject to INIT", state_o, 0);
      chk("R2 prm_err set", prm_err, 1);
      send_prm(8'h21);
      tick();
      chk("R2 accept to CONFIG", state_o, 2);
      chk("R3 start pulse", cfg_start, 1);
      chk("R2 prm_err clear", prm_err, 0);
      chk("R2 alg_prm", alg_prm, 8'h21);
      tick();
      chk("R3 start single", cfg_start, 0);
      chk("R3 no run in CONFIG", run_en, 0);
      chk("R4 waits for ready", state_o, 2);
      give_ready(8);
      tick();
      chk("R10 no change at balance", state_o, 3);
   endtask

   task automatic t_tput();
      req_tput = 8'd20;
      tick();
      chk("R9 step up state", state_o, 2);
      chk("R9 step up id", cfg_id, 1);
      chk("R9 start pulse", cfg_start, 1);
      give_ready(12);
      tick();
      tick();
      chk("R10 hold in band", state_o, 3);
      chk("R10 hold id", cfg_id, 1);
      req_tput = 8'd4;
      tick();
      chk("R10 step down state", state_o, 2);
      chk("R10 step down id", cfg_id, 0);
      give_ready(8);
   endtask

   task automatic t_table();
      tbl_idx  = 3'd0;
      tbl_data = 8'd4;
      tbl_wr   = 1'b1;
      tick();
      tbl_wr = 1'b0;
      chk("R13 old entry still used", state_o, 3);
      tick();
      chk("R13 new entry drives step", state_o, 2);
      chk("R13 id after write", cfg_id, 1);
      give_ready(8);
      tick();
      chk("R13 hold at id 1", cfg_id, 1);
   endtask

   task automatic t_power();
      batt_low = 1'b1;
      tick();
      chk("R11 battery step down", cfg_id, 0);
      chk("R11 battery to CONFIG", state_o, 2);
      give_ready(100);
      tick();
      chk("R12 power blocks step up", state_o, 3);
      chk("R11 floor at id 0", cfg_id, 0);
      batt_low = 1'b0;
      tick();
      chk("R9 up after power clears", cfg_id, 1);
      give_ready(12);
      chan_q = 4'd2;
      tick();
      chk("R11 channel step down", cfg_id, 0);
      chk("R11 channel to CONFIG", state_o, 2);
      chan_q = 4'd9;
      give_ready(4);
   endtask

   task automatic t_security();
      sec_req  = 1'b1;
      batt_low = 1'b1;
      tick();
      chk("R8 forced CONFIG", state_o, 2);
      chk("R8 start pulse", cfg_start, 1);
      chk("R12 sec over power id", cfg_id, 0);
      prim_ready = 1'b1;
      tick();
      chk("R8 hold in CONFIG", state_o, 2);
      chk("R8 single pulse", cfg_start, 0);
      sec_req  = 1'b0;
      batt_low = 1'b0;
      tick();
      prim_ready = 1'b0;
      chk("R4 RUN after release", state_o, 3);
   endtask

   task automatic t_finish();
      prim_done   = 1'b1;
      keep_loaded = 1'b1;
      tick();
      prim_done = 1'b0;
      chk("R5 to IDLE", state_o, 4);
      chk("R3 run_en off", run_en, 0);
      tick();
      chk("R6 IDLE holds", state_o, 4);
      restart = 1'b1;
      tick();
      restart = 1'b0;
      chk("R6 restart to INIT", state_o, 0);
      send_prm(8'h10);
      tick();
      chk("R2 CONFIG again", state_o, 2);
      give_ready(4);
      prim_done   = 1'b1;
      keep_loaded = 1'b0;
      tick();
      prim_done = 1'b0;
      chk("R5 to STOP", state_o, 5);
      send_prm(8'h22);
      tick();
      chk("R7 STOP reparam CONFIG", state_o, 2);
      chk("R7 alg_prm", alg_prm, 8'h22);
   endtask

   task automatic t_more();
      give_ready(4);
      prim_done   = 1'b1;
      keep_loaded = 1'b1;
      tick();
      prim_done = 1'b0;
      chk("R5 IDLE", state_o, 4);
      sec_req = 1'b1;
      tick();
      sec_req = 1'b0;
      chk("R8 from IDLE", state_o, 2);
      chk("R8 pulse from IDLE", cfg_start, 1);
      give_ready(4);
      prm_data  = 8'h13;
      prm_wr    = 1'b1;
      prim_done = 1'b1;
      tick();
      prm_wr    = 1'b0;
      prim_done = 1'b0;
      chk("R12 prm_wr over done", state_o, 1);
      tick();
      chk("R7 bad word to INIT", state_o, 0);
      chk("R7 prm_err", prm_err, 1);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_params();
      t_tput();
      t_table();
      t_power();
      t_security();
      t_finish();
      t_more();
      done_flag = 1'b1;
   end

   initial begin
      for (int i = 0; i < 5000; i++) begin
         if (done_flag) break;
         @(posedge clk);
      end
      if (!done_flag) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule